// File: doc/BRIEF.md
# Capture/Compare Counter Array

This block is a 16-bit counter that runs freely and is shared by five capture/compare channels. Each channel has its own 7-bit mode register and a 16-bit capture/compare register. Depending on its mode bits, a channel can do the following:

- latch the counter on chosen edges of its capture pin;
- raise a flag when the counter steps onto its compare value;
- invert its output pin on such a match;
- drive a pulse-width modulated output from its compare value.

The counter can take its steps from four sources, chosen by software:

- a divide-by-12 of the clock;
- a divide-by-2 of the clock;
- a timer tick input;
- falling edges of an asynchronous pin.

Each channel flag has its own enable. The counter wrap flag also has an enable. The enabled flags are combined with an array-level enable and a global enable into a single interrupt request.

Software reaches every register through a plain byte-wide register port. Writes take effect at the clock edge where `bus_we_i` is high. Reads are combinational from `bus_addr_i`. Nothing in the block moves as a stream, so there is no valid/ready handshake and no back-pressure. Each pin is a level or an edge, sampled every clock.

Top module: `cnt_capcmp_array`

## Requirements
- R1: After reset, every register reads 0x00, every channel output is low and `irq_o` is low.
- R2: Register addresses are as follows:
  - 0x00 is the control register: bit 7 is the wrap flag, bit 6 is run, and bits 4:0 are the channel flags.
  - 0x01 is the counter mode register: bit 0 is the wrap interrupt enable, and bits 2:1 are the step source.
  - 0x02 and 0x03 are the counter low and high bytes.
  - 0x08+n is the mode register of channel n.
  - 0x10+2n and 0x11+2n are the low and high bytes of channel n's capture/compare register.
- R3: The counter steps only while run is set. Every step source is ignored while run is clear. The step source codes are:
  - 00: one step every 12 clocks;
  - 01: one step every 2 clocks;
  - 10: one step per clock in which `tick_i` is high;
  - 11: one step per falling edge of `ext_clk_i`, after a two-flop synchroniser.
- R4: Software writes to the counter bytes load them directly. A read returns the live count.
- R5: When the counter steps from 0xFFFF it wraps to 0x0000 and sets control bit 7.
- R6: A capture latches the counter into the channel's capture/compare register and sets the channel's flag. The capture pins pass through two flops before edge detection. Mode bit 5 enables capture on a rising edge and mode bit 4 on a falling edge; with both set, either edge captures. An edge that is not enabled has no effect.
- R7: With mode bit 6 (compare enable) and bit 3 (match flag) set, a counter step onto the channel's compare value sets the channel flag.
- R8: With mode bits 6 and 2 set and bit 1 clear, each match inverts the channel output. A match does not set the flag unless bit 3 is also set.
- R9: With mode bits 6 and 1 set, the output is pulse-width modulated:
  - it is high while the counter low byte is below a shadow byte, and low otherwise;
  - the shadow byte is reloaded from the high byte of the capture/compare register only when the counter low byte rolls from 0xFF to 0x00.
- R10: `irq_o` is high when all three of these hold:
  - either control bit 7 is set with counter mode bit 0 set, or some channel flag is set with that channel's mode bit 0 set;
  - `irq_array_en_i` is high;
  - `irq_global_en_i` is high.
- R11: Flags stay set until software writes the control register. A control write loads bits 7 and 4:0 as written. When a write meets a hardware set in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| tick_i | input | 1 | Timer tick step source |
| ext_clk_i | input | 1 | Asynchronous external step pin |
| cap_i | input | 5 | Asynchronous capture pins, one per channel |
| irq_array_en_i | input | 1 | Array-level interrupt enable |
| irq_global_en_i | input | 1 | Global interrupt enable |
| chan_out_o | output | 5 | Channel outputs |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench gates the run bit over exact windows of 24 clocks, so a prescaler that is off by one, or that ignores run, gives the wrong count. A wrong result in any of these cases shows up as a wrong register value or pin level:

- **Wrap:** the wrap at 0xFFFF must set the wrap flag and raise the interrupt, and the interrupt must fall when the array enable drops.
- **Capture edges:** captures are tried with rising-only, falling-only and both-edge modes. A design that decodes bits 4 and 5 the wrong way round latches on the wrong edge.
- **Match timing:** the match flag must appear on the step onto the compare value, not one step early or late.
- **Toggle without flag:** a toggle-only channel must leave its flag clear.
- **PWM shadow:** the high byte is rewritten in the middle of a PWM period. A design that compares against the register instead of the shadow changes its output too early.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int NUM_CH_DEF  = 5;
  localparam int BYTE_W      = 8;
  localparam int MODE_W      = 7;

  typedef enum logic [1:0] {
    SRC_DIV_SLOW = 2'b00,
    SRC_DIV_FAST = 2'b01,
    SRC_TICK     = 2'b10,
    SRC_EXT      = 2'b11
  } step_src_e;

  // register addresses
  localparam int A_CTRL      = 'h00;
  localparam int A_CMODE     = 'h01;
  localparam int A_CNT_LO    = 'h02;
  localparam int A_CNT_HI    = 'h03;
  localparam int A_MODE_BASE = 'h08;
  localparam int A_CCAP_BASE = 'h10;

  // channel mode bit positions
  localparam int MB_IE   = 0;
  localparam int MB_PWM  = 1;
  localparam int MB_TOG  = 2;
  localparam int MB_MAT  = 3;
  localparam int MB_CAPN = 4;
  localparam int MB_CAPP = 5;
  localparam int MB_ECOM = 6;
endpackage

// File: rtl/pcc_timebase.sv
module pcc_timebase
  import pcc_pkg::*;
#(
  parameter int CNT_BYTE_W  = 8,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_i,
  input  logic [1:0]              src_i,
  input  logic                    tick_i,
  input  logic                    ext_i,
  input  logic                    wr_lo_i,
  input  logic                    wr_hi_i,
  input  logic [CNT_BYTE_W-1:0]   wdata_i,
  output logic [2*CNT_BYTE_W-1:0] cnt_o,
  output logic [2*CNT_BYTE_W-1:0] cnt_next_o,
  output logic                    adv_o,
  output logic                    wrap_o,
  output logic                    lo_wrap_o
);
  localparam int CNT_W = 2 * CNT_BYTE_W;
  localparam int PRE_W = $clog2(DIV_SLOW);

  logic [CNT_W-1:0]     cnt_q;
  logic [PRE_W-1:0]     pre_q;
  logic [PRE_W-1:0]     pre_lim;
  logic [SYNC_STAGES:0] ext_sh;
  logic                 ext_fall;
  logic                 step;
  logic                 use_div;

  assign use_div  = (src_i == SRC_DIV_SLOW) || (src_i == SRC_DIV_FAST);
  assign pre_lim  = (src_i == SRC_DIV_SLOW) ? PRE_W'(DIV_SLOW - 1) : PRE_W'(DIV_FAST - 1);
  // synchronised level high one clock ago, low now
  assign ext_fall = ext_sh[SYNC_STAGES] & ~ext_sh[SYNC_STAGES-1];

  always_comb begin
    case (step_src_e'(src_i))
      SRC_DIV_SLOW, SRC_DIV_FAST: step = (pre_q == pre_lim);
      SRC_TICK:                   step = tick_i;
      default:                    step = ext_fall;
    endcase
  end

  assign adv_o      = run_i & step;
  assign cnt_next_o = cnt_q + 1'b1;
  assign wrap_o     = adv_o & (cnt_q == {CNT_W{1'b1}});
  assign lo_wrap_o  = adv_o & (cnt_q[CNT_BYTE_W-1:0] == {CNT_BYTE_W{1'b1}});
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      ext_sh <= '0;
    end else begin
      ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_i};
      if (!run_i || !use_div)    pre_q <= '0;
      else if (pre_q == pre_lim) pre_q <= '0;
      else                       pre_q <= pre_q + 1'b1;
      if (wr_lo_i || wr_hi_i) begin
        if (wr_lo_i) cnt_q[CNT_BYTE_W-1:0]     <= wdata_i;
        if (wr_hi_i) cnt_q[CNT_W-1:CNT_BYTE_W] <= wdata_i;
      end else if (adv_o) begin
        cnt_q <= cnt_next_o;
      end
    end
  end
endmodule

// File: rtl/pcc_channel.sv
module pcc_channel
  import pcc_pkg::*;
#(
  parameter int CNT_BYTE_W  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic [2*CNT_BYTE_W-1:0] cnt_i,
  input  logic [2*CNT_BYTE_W-1:0] cnt_next_i,
  input  logic                    adv_i,
  input  logic                    lo_wrap_i,
  input  logic                    cap_i,
  input  logic                    wr_lo_i,
  input  logic                    wr_hi_i,
  input  logic [CNT_BYTE_W-1:0]   wdata_i,
  output logic [2*CNT_BYTE_W-1:0] ccap_o,
  output logic                    flag_set_o,
  output logic                    tog_o,
  output logic                    out_o
);
  localparam int CNT_W = 2 * CNT_BYTE_W;

  logic [CNT_W-1:0]      ccap_q;
  logic [CNT_BYTE_W-1:0] shadow_q;
  logic [SYNC_STAGES:0]  cap_sh;
  logic                  tog_q;
  logic                  rise, fall, cap_evt, match, pwm_on;

  assign rise    = cap_sh[SYNC_STAGES-1] & ~cap_sh[SYNC_STAGES];
  assign fall    = ~cap_sh[SYNC_STAGES-1] & cap_sh[SYNC_STAGES];
  assign cap_evt = (mode_i[MB_CAPP] & rise) | (mode_i[MB_CAPN] & fall);
  assign match   = mode_i[MB_ECOM] & adv_i & (cnt_next_i == ccap_q);
  assign pwm_on  = mode_i[MB_ECOM] & mode_i[MB_PWM];

  assign flag_set_o = cap_evt | (match & mode_i[MB_MAT]);
  assign out_o      = pwm_on ? (cnt_i[CNT_BYTE_W-1:0] < shadow_q) : tog_q;
  assign ccap_o     = ccap_q;
  assign tog_o      = tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccap_q   <= '0;
      shadow_q <= '0;
      cap_sh   <= '0;
      tog_q    <= 1'b0;
    end else begin
      cap_sh <= {cap_sh[SYNC_STAGES-1:0], cap_i};
      if (cap_evt) begin
        ccap_q <= cnt_i;
      end else begin
        if (wr_lo_i) ccap_q[CNT_BYTE_W-1:0]     <= wdata_i;
        if (wr_hi_i) ccap_q[CNT_W-1:CNT_BYTE_W] <= wdata_i;
      end
      if (lo_wrap_i) shadow_q <= ccap_q[CNT_W-1:CNT_BYTE_W];
      if (match && mode_i[MB_TOG] && !mode_i[MB_PWM]) tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/cnt_capcmp_array.sv
module cnt_capcmp_array
  import pcc_pkg::*;
#(
  parameter int NUM_CH      = NUM_CH_DEF,
  parameter int ADDR_W      = 5,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic              tick_i,
  input  logic              ext_clk_i,
  input  logic [NUM_CH-1:0] cap_i,
  input  logic              irq_array_en_i,
  input  logic              irq_global_en_i,
  output logic [NUM_CH-1:0] chan_out_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic                            run_q, ovf_q, ovf_ie_q;
  logic [1:0]                      src_q;
  logic [NUM_CH-1:0]               flags_q;
  logic [NUM_CH-1:0][MODE_W-1:0]   mode_q;
  logic [NUM_CH-1:0][CNT_W-1:0]    ccap;
  logic [NUM_CH-1:0]               flag_set, tog_vec, ie_vec, wr_lo, wr_hi;
  logic [CNT_W-1:0]                cnt, cnt_next;
  logic                            adv, wrap, lo_wrap, cnt_wr_lo, cnt_wr_hi, cnt_wr;
  logic                            wr_ctrl, wr_cmode;

  assign wr_ctrl   = bus_we_i && (bus_addr_i == ADDR_W'(A_CTRL));
  assign wr_cmode  = bus_we_i && (bus_addr_i == ADDR_W'(A_CMODE));
  assign cnt_wr_lo = bus_we_i && (bus_addr_i == ADDR_W'(A_CNT_LO));
  assign cnt_wr_hi = bus_we_i && (bus_addr_i == ADDR_W'(A_CNT_HI));
  assign cnt_wr    = cnt_wr_lo | cnt_wr_hi;

  pcc_timebase #(
    .CNT_BYTE_W(BYTE_W), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .SYNC_STAGES(SYNC_STAGES)
  ) i_timebase (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .src_i(src_q), .tick_i(tick_i),
    .ext_i(ext_clk_i), .wr_lo_i(cnt_wr_lo), .wr_hi_i(cnt_wr_hi), .wdata_i(bus_wdata_i),
    .cnt_o(cnt), .cnt_next_o(cnt_next), .adv_o(adv), .wrap_o(wrap), .lo_wrap_o(lo_wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_mode;
    assign wr_mode  = bus_we_i && (bus_addr_i == ADDR_W'(A_MODE_BASE + g));
    assign wr_lo[g] = bus_we_i && (bus_addr_i == ADDR_W'(A_CCAP_BASE + 2 * g));
    assign wr_hi[g] = bus_we_i && (bus_addr_i == ADDR_W'(A_CCAP_BASE + 2 * g + 1));
    assign ie_vec[g] = mode_q[g][MB_IE];

    always_ff @(posedge clk) begin
      if (!rst_n)       mode_q[g] <= '0;
      else if (wr_mode) mode_q[g] <= bus_wdata_i[MODE_W-1:0];
    end

    pcc_channel #(.CNT_BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) i_chan (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_q[g]), .cnt_i(cnt), .cnt_next_i(cnt_next),
      .adv_i(adv), .lo_wrap_i(lo_wrap), .cap_i(cap_i[g]), .wr_lo_i(wr_lo[g]),
      .wr_hi_i(wr_hi[g]), .wdata_i(bus_wdata_i), .ccap_o(ccap[g]),
      .flag_set_o(flag_set[g]), .tog_o(tog_vec[g]), .out_o(chan_out_o[g])
    );
  end

  // control and counter mode registers; hardware sets beat software writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      ovf_q    <= 1'b0;
      flags_q  <= '0;
      ovf_ie_q <= 1'b0;
      src_q    <= 2'b00;
    end else begin
      if (wr_ctrl) begin
        run_q   <= bus_wdata_i[6];
        ovf_q   <= bus_wdata_i[7] | wrap;
        flags_q <= bus_wdata_i[NUM_CH-1:0] | flag_set;
      end else begin
        ovf_q   <= ovf_q | wrap;
        flags_q <= flags_q | flag_set;
      end
      if (wr_cmode) begin
        ovf_ie_q <= bus_wdata_i[0];
        src_q    <= bus_wdata_i[2:1];
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_W'(A_CTRL): begin
        bus_rdata_o[7]          = ovf_q;
        bus_rdata_o[6]          = run_q;
        bus_rdata_o[NUM_CH-1:0] = flags_q;
      end
      ADDR_W'(A_CMODE):  bus_rdata_o = {5'b0, src_q, ovf_ie_q};
      ADDR_W'(A_CNT_LO): bus_rdata_o = cnt[BYTE_W-1:0];
      ADDR_W'(A_CNT_HI): bus_rdata_o = cnt[CNT_W-1:BYTE_W];
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (bus_addr_i == ADDR_W'(A_MODE_BASE + i))
            bus_rdata_o = {{(BYTE_W-MODE_W){1'b0}}, mode_q[i]};
          if (bus_addr_i == ADDR_W'(A_CCAP_BASE + 2 * i))
            bus_rdata_o = ccap[i][BYTE_W-1:0];
          if (bus_addr_i == ADDR_W'(A_CCAP_BASE + 2 * i + 1))
            bus_rdata_o = ccap[i][CNT_W-1:BYTE_W];
        end
      end
    endcase
  end

  assign irq_o = irq_global_en_i & irq_array_en_i &
                 ((ovf_q & ovf_ie_q) | (|(flags_q & ie_vec)));
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic              adv,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic              wrap,
  input logic              ovf_q,
  input logic [NUM_CH-1:0] flag_set,
  input logic [NUM_CH-1:0] flags_q,
  input logic [NUM_CH-1:0] tog_vec,
  input logic              irq_o,
  input logic              irq_global_en_i
);
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr) |=> $stable(cnt));

  a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_q);

  a_r11_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_set) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

  a_r8_toggle_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(tog_vec));

  a_r10_irq_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_global_en_i |-> !irq_o);

  a_r10_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ovf_q || (|flags_q)));
endmodule

bind cnt_capcmp_array pcc_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .adv(adv), .cnt_wr(cnt_wr), .cnt(cnt),
  .wrap(wrap), .ovf_q(ovf_q), .flag_set(flag_set), .flags_q(flags_q),
  .tog_vec(tog_vec), .irq_o(irq_o), .irq_global_en_i(irq_global_en_i)
);

// File: tb/test_cnt_capcmp_array.sv
`timescale 1ns/1ps
module test_cnt_capcmp_array;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick = 1'b0, ext = 1'b0;
  logic [4:0] cap = '0;
  logic       arr_en = 1'b1, glb_en = 1'b1;
  logic [4:0] cout;
  logic       irq;
  int         checks = 0, errors = 0;

  always #2 clk = ~clk;

  cnt_capcmp_array i_cnt_capcmp_array (
    .clk(clk), .rst_n(rst_n), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .tick_i(tick), .ext_clk_i(ext), .cap_i(cap),
    .irq_array_en_i(arr_en), .irq_global_en_i(glb_en), .chan_out_o(cout), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd16(input logic [4:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 5'd1, hi); d = {hi, lo};
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(5'h02, v[7:0]); wr(5'h03, v[15:8]);
  endtask

  task automatic pulse_tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(5'h00, d); check("R1 ctrl", {8'h0, d}, 16'h0000);
    rd(5'h01, d); check("R1 cmode", {8'h0, d}, 16'h0000);
    rd(5'h12, d); check("R1 ccap1 lo", {8'h0, d}, 16'h0000);
    check("R1 outputs", {11'h0, cout}, 16'h0000);
    check("R1 irq", {15'h0, irq}, 16'h0000);
  endtask

  task automatic t_dividers;
    logic [15:0] v;
    wr(5'h01, 8'h02); set_cnt(16'h0000);
    wr(5'h00, 8'h40); wait_cyc(22); wr(5'h00, 8'h00);
    rd16(5'h02, v); check("R3 div2 24 clocks", v, 16'd12);
    wr(5'h01, 8'h00); set_cnt(16'h0000);
    wr(5'h00, 8'h40); wait_cyc(22); wr(5'h00, 8'h00);
    rd16(5'h02, v); check("R3 div12 24 clocks", v, 16'd2);
  endtask

  task automatic t_tick_ext;
    logic [15:0] v;
    wr(5'h01, 8'h04); set_cnt(16'h0000);
    pulse_tick(3);
    rd16(5'h02, v); check("R3 ticks ignored while stopped", v, 16'd0);
    wr(5'h00, 8'h40); pulse_tick(5); wr(5'h00, 8'h00);
    rd16(5'h02, v); check("R3 tick source", v, 16'd5);
    set_cnt(16'h0100);
    rd16(5'h02, v); check("R4 counter load", v, 16'h0100);
    wr(5'h01, 8'h06); set_cnt(16'h0000); wr(5'h00, 8'h40);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); ext = 1'b1; wait_cyc(5);
      ext = 1'b0; wait_cyc(5);
    end
    wr(5'h00, 8'h00);
    rd16(5'h02, v); check("R3 ext falling edges", v, 16'd3);
  endtask

  task automatic t_wrap_irq;
    logic [15:0] v; logic [7:0] d;
    wr(5'h01, 8'h05); set_cnt(16'hFFFF); wr(5'h00, 8'h40);
    check("R10 irq before wrap", {15'h0, irq}, 16'h0);
    pulse_tick(1);
    rd16(5'h02, v); check("R5 wrap to zero", v, 16'h0000);
    rd(5'h00, d); check("R5 wrap flag", {8'h0, d}, 16'h00C0);
    check("R10 irq on wrap", {15'h0, irq}, 16'h1);
    @(negedge clk); arr_en = 1'b0; #1;
    check("R10 array enable gates", {15'h0, irq}, 16'h0);
    arr_en = 1'b1; #1;
    check("R10 irq restored", {15'h0, irq}, 16'h1);
    wr(5'h00, 8'h00);
    check("R11 clear drops irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_capture;
    logic [15:0] v; logic [7:0] d;
    wr(5'h08, 8'h20);
    rd(5'h08, d); check("R2 mode readback", {8'h0, d}, 16'h0020);
    set_cnt(16'h1234);
    @(negedge clk); cap[0] = 1'b1; wait_cyc(5);
    rd16(5'h10, v); check("R6 rising capture", v, 16'h1234);
    rd(5'h00, d); check("R6 capture flag", {8'h0, d}, 16'h0001);
    wr(5'h00, 8'h00); set_cnt(16'h5678);
    @(negedge clk); cap[0] = 1'b0; wait_cyc(5);
    rd16(5'h10, v); check("R6 falling ignored value", v, 16'h1234);
    rd(5'h00, d); check("R6 falling ignored flag", {8'h0, d}, 16'h0000);
    wr(5'h0A, 8'h30);
    @(negedge clk); cap[2] = 1'b1; wait_cyc(5);
    rd16(5'h14, v); check("R6 both edges rise", v, 16'h5678);
    set_cnt(16'h9ABC);
    @(negedge clk); cap[2] = 1'b0; wait_cyc(5);
    rd16(5'h14, v); check("R6 both edges fall", v, 16'h9ABC);
    wr(5'h09, 8'h10); set_cnt(16'h0F0F);
    @(negedge clk); cap[1] = 1'b1; wait_cyc(5);
    rd16(5'h12, v); check("R6 fall-only ignores rise", v, 16'h0000);
    @(negedge clk); cap[1] = 1'b0; wait_cyc(5);
    rd16(5'h12, v); check("R6 fall-only captures", v, 16'h0F0F);
    wr(5'h08, 8'h00); wr(5'h09, 8'h00); wr(5'h0A, 8'h00); wr(5'h00, 8'h00);
  endtask

  task automatic t_match;
    logic [7:0] d;
    wr(5'h01, 8'h04); wr(5'h12, 8'h03); wr(5'h13, 8'h00);
    wr(5'h09, 8'h49); set_cnt(16'h0000); wr(5'h00, 8'h40);
    pulse_tick(2);
    rd(5'h00, d); check("R7 no flag before match", {8'h0, d}, 16'h0040);
    check("R10 no irq before match", {15'h0, irq}, 16'h0);
    pulse_tick(1);
    rd(5'h00, d); check("R7 flag on match", {8'h0, d}, 16'h0042);
    check("R10 channel irq", {15'h0, irq}, 16'h1);
    pulse_tick(2);
    rd(5'h00, d); check("R11 flag stays set", {8'h0, d}, 16'h0042);
    wr(5'h00, 8'h00); wr(5'h09, 8'h00);
  endtask

  task automatic t_toggle;
    logic [7:0] d;
    wr(5'h0B, 8'h44); wr(5'h16, 8'h02); wr(5'h17, 8'h00);
    set_cnt(16'h0000); wr(5'h00, 8'h40);
    pulse_tick(1);
    check("R8 no toggle before match", {15'h0, cout[3]}, 16'h0);
    pulse_tick(1);
    check("R8 toggle on match", {15'h0, cout[3]}, 16'h1);
    rd(5'h00, d); check("R8 no flag without match bit", {8'h0, d}, 16'h0040);
    set_cnt(16'h0000); pulse_tick(2);
    check("R8 second toggle", {15'h0, cout[3]}, 16'h0);
    wr(5'h00, 8'h00); wr(5'h0B, 8'h00);
  endtask

  task automatic t_pwm;
    wr(5'h0C, 8'h42); wr(5'h19, 8'h40); set_cnt(16'h00F0); wr(5'h00, 8'h40);
    check("R9 shadow zero keeps low", {15'h0, cout[4]}, 16'h0);
    pulse_tick(16);
    check("R9 high after reload", {15'h0, cout[4]}, 16'h1);
    pulse_tick(63);
    check("R9 high below duty", {15'h0, cout[4]}, 16'h1);
    pulse_tick(1);
    check("R9 low at duty", {15'h0, cout[4]}, 16'h0);
    wr(5'h19, 8'h80);
    check("R9 new duty waits for rollover", {15'h0, cout[4]}, 16'h0);
    wr(5'h00, 8'h00);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset;
    t_dividers;
    t_tick_ext;
    t_wrap_irq;
    t_capture;
    t_match;
    t_toggle;
    t_pwm;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule